// File: doc/BRIEF.md
# Programmable-Priority Bus Master Arbiter

This block decides which of four internal clients may drive a shared bus master port. The clients are a bulk DMA engine, a processor core port, a receive-queue port and a status port. Each client raises a request line and receives a one-hot grant. A client keeps its grant for as long as it holds its request. After the client drops its request, the grant is withdrawn. One cycle later the next decision is made.

An 8-bit priority word gives each client a 2-bit level. While the whole word is zero, the arbiter rotates fairly among the requesting clients. If any bit of the word is set, the arbiter switches to fixed levels and the highest level wins. The block also drives a registered hurry-up hint to the DMA engine. The hint asks the DMA engine to finish quickly while selected other clients are left waiting. Each of the three waiting sources has its own enable bit.

Top module: `ppa_arbiter`

## Requirements
- R1: Out of reset `grant` is 0 and `dma_hurry` is 0. At no time is more than one bit of `grant` set.
- R2: Requestor indices are 0 = DMA engine, 1 = core, 2 = receive queue, 3 = status port, and `grant[i]` is the grant of requestor i. When no grant is active and at least one request is high at a clock edge, a grant goes to one of the requesting clients on that edge. When no request is high, no grant appears.
- R3: A grant holds unchanged while its owner keeps its request high, whatever other requests or configuration do meanwhile.
- R4: When the owner lowers its request, `grant` goes to 0 on the next edge and stays 0 for at least one cycle before any new grant, even if other requests are pending.
- R5: The level fields are `prio_cfg[7:6]` for the DMA engine, `[5:4]` for the core, `[3:2]` for the receive queue and `[1:0]` for the status port. If any bit is nonzero, the requesting client with the numerically highest level is granted.
- R6: In level mode, when requesting clients share the highest level, the lowest index among them is granted.
- R7: When `prio_cfg` is all zero, the search begins at the index after the most recently granted client and wraps from 3 to 0. A grant in either mode counts as the most recent one. After reset the search begins at index 0.
- R8: A client waits when its request is high and it is not granted. `hurry_en[0]` enables the status port as a hurry source, `hurry_en[1]` the receive queue and `hurry_en[2]` the core. `dma_hurry` is registered: it is high in the cycle after an edge at which some enabled source was waiting.
- R9: `dma_hurry` falls on the first edge at which no enabled source is waiting.
- R10: `prio_cfg` is sampled only when a grant decision is made. A change while a grant is held affects only the next decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Request per client, index as in R2 |
| prio_cfg | input | 8 | Per-client priority levels, all zero selects rotation |
| hurry_en | input | 3 | Hurry-source enables: status, receive queue, core |
| grant | output | 4 | One-hot grant per client |
| dma_hurry | output | 1 | Registered hurry-up hint to the DMA engine |

## Verification
The assertions check the port-level rules on every cycle. They cover the one-hot grant, grants issued only to clients that requested, holding while the owner requests, the empty cycle after a release, no grant without a request, and the hint following the enabled waiting sources one cycle later. Which client wins a decision depends on the rotation pointer and the priority levels. Only the bench shows this. It sweeps every priority word against every request pattern with a reference model. Directed scenarios cover configuration changes during a held grant and the hint's rise and fall for each source.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int N_REQ  = 4;
    localparam int LVL_W  = 2;
    localparam int CFG_W  = N_REQ * LVL_W;
    localparam int HINT_N = N_REQ - 1;
    localparam int IDX_W  = $clog2(N_REQ);

    typedef logic [N_REQ-1:0] req_vec_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [CFG_W-1:0] cfg_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OWNED = 1'b1
    } arb_state_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } pick_t;

    // Requestor 0 owns the top field, the last requestor the bottom one.
    function automatic lvl_t level_of(input cfg_t cfg, input int i);
        return cfg[CFG_W-1-LVL_W*i -: LVL_W];
    endfunction

    function automatic req_vec_t idx_to_onehot(input idx_t idx);
        req_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick
    import arb_pkg::*;
(
    input  req_vec_t req,
    input  cfg_t     cfg,
    output pick_t    pick
);
    lvl_t best_lvl;

    always_comb begin
        pick     = '0;
        best_lvl = '0;
        for (int i = 0; i < N_REQ; i++) begin
            // strict compare keeps the lower index on equal levels
            if (req[i] && (!pick.valid || level_of(cfg, i) > best_lvl)) begin
                pick.valid = 1'b1;
                pick.idx   = idx_t'(i);
                best_lvl   = level_of(cfg, i);
            end
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick
    import arb_pkg::*;
(
    input  req_vec_t req,
    input  idx_t     last,
    output pick_t    pick
);
    idx_t cand;

    always_comb begin
        pick = '0;
        cand = '0;
        for (int k = 1; k <= N_REQ; k++) begin
            cand = idx_t'((int'(last) + k) % N_REQ);
            if (!pick.valid && req[cand]) begin
                pick.valid = 1'b1;
                pick.idx   = cand;
            end
        end
    end
endmodule

// File: rtl/arb_hurry_gen.sv
module arb_hurry_gen
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  req_vec_t          req,
    input  req_vec_t          grant,
    input  logic [HINT_N-1:0] en,
    output logic              hurry
);
    req_vec_t          waiting;
    logic [HINT_N-1:0] src_hit;

    assign waiting = req & ~grant;

    // enable bit s watches requestor N_REQ-1-s (status first, then upward)
    for (genvar s = 0; s < HINT_N; s++) begin : g_src
        assign src_hit[s] = en[s] & waiting[N_REQ-1-s];
    end

    always_ff @(posedge clk) begin
        if (rst) hurry <= 1'b0;
        else     hurry <= |src_hit;
    end
endmodule

// File: rtl/ppa_arbiter.sv
module ppa_arbiter
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] req,
    input  logic [7:0] prio_cfg,
    input  logic [2:0] hurry_en,
    output logic [3:0] grant,
    output logic       dma_hurry
);
    arb_state_t state;
    idx_t       owner;
    idx_t       last_idx;
    pick_t      prio_pick;
    pick_t      rr_pick;
    pick_t      sel;
    logic       level_mode;

    assign level_mode = |prio_cfg;

    arb_prio_pick u_prio (
        .req  (req),
        .cfg  (prio_cfg),
        .pick (prio_pick)
    );

    arb_rr_pick u_rr (
        .req  (req),
        .last (last_idx),
        .pick (rr_pick)
    );

    assign sel = level_mode ? prio_pick : rr_pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            grant    <= '0;
            owner    <= '0;
            last_idx <= idx_t'(N_REQ - 1);
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sel.valid) begin
                        grant    <= idx_to_onehot(sel.idx);
                        owner    <= sel.idx;
                        last_idx <= sel.idx;
                        state    <= ST_OWNED;
                    end
                end
                ST_OWNED: begin
                    if (!req[owner]) begin
                        grant <= '0;
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    grant <= '0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    arb_hurry_gen u_hurry (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .grant (grant),
        .en    (hurry_en),
        .hurry (dma_hurry)
    );
endmodule

// File: rtl/ppa_arbiter_chk.sv
module ppa_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] req,
    input logic [7:0] prio_cfg,
    input logic [2:0] hurry_en,
    input logic [3:0] grant,
    input logic       dma_hurry
);
    logic [3:0] wait_v;
    logic       hint_cond;

    assign wait_v    = req & ~grant;
    assign hint_cond = (hurry_en[0] & wait_v[3]) | (hurry_en[1] & wait_v[2])
                     | (hurry_en[2] & wait_v[1]);

    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R2
    gnt_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        (grant == 4'b0 && req != 4'b0) |=> ((grant & $past(req)) != 4'b0));

    // R2
    no_req_no_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (grant == 4'b0 && req == 4'b0) |=> (grant == 4'b0));

    // R3
    gnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((grant & req) != 4'b0) |=> (grant == $past(grant)));

    // R4
    gnt_release_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != 4'b0 && (grant & req) == 4'b0) |=> (grant == 4'b0));

    // R8
    hurry_follow_chk: assert property (@(posedge clk) disable iff (rst)
        hint_cond |=> dma_hurry);

    // R9
    hurry_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !hint_cond |=> !dma_hurry);
endmodule

bind ppa_arbiter ppa_arbiter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .prio_cfg  (prio_cfg),
    .hurry_en  (hurry_en),
    .grant     (grant),
    .dma_hurry (dma_hurry)
);

// File: tb/ppa_arbiter_bench.sv
`timescale 1ns/1ps
module ppa_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = '0;
    logic [7:0] prio_cfg = '0;
    logic [2:0] hurry_en = '0;
    logic [3:0] grant;
    logic       dma_hurry;

    int checks   = 0;
    int failures = 0;
    int last_m   = 3;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ppa_arbiter u_ppa_arbiter (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .prio_cfg  (prio_cfg),
        .hurry_en  (hurry_en),
        .grant     (grant),
        .dma_hurry (dma_hurry)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_gnt(input string tag, input logic [3:0] exp);
        checks++;
        if (grant !== exp) begin
            failures++;
            $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic chk_hurry(input string tag, input logic exp);
        checks++;
        if (dma_hurry !== exp) begin
            failures++;
            $display("FAIL %s dma_hurry actual=%b expected=%b", tag, dma_hurry, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req = '0;
        step();
        step();
        rst = 1'b0;
        last_m = 3;
    endtask

    // reference model of a decision made from idle
    function automatic int model_pick(input logic [7:0] cfg, input logic [3:0] r);
        int best = -1;
        int bl   = -1;
        if (r == 4'b0) return -1;
        if (cfg == 8'h00) begin
            for (int k = 1; k <= 4; k++) begin
                int j = (last_m + k) % 4;
                if (r[j]) return j;
            end
        end
        for (int i = 0; i < 4; i++) begin
            int lv = (cfg >> (6 - 2 * i)) & 3;
            if (r[i] && lv > bl) begin
                bl   = lv;
                best = i;
            end
        end
        return best;
    endfunction

    function automatic logic [3:0] oh(input int i);
        return (i < 0) ? 4'b0 : (4'b1 << i);
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        chk_gnt("R1 reset", 4'b0);
        chk_hurry("R1 reset", 1'b0);

        // R7: rotation from reset starts at 0 and walks upward
        for (int n = 0; n < 5; n++) begin
            req = 4'b1111;
            step();
            chk_gnt("R7 rotate", oh(n % 4));
            req = 4'b0;
            step();
            chk_gnt("R4 release", 4'b0);
        end

        // R5 R6 R7 R2: sweep every priority word against every request pattern
        do_reset();
        for (int c = 0; c < 256; c++) begin
            for (int p = 0; p < 16; p++) begin
                int e;
                prio_cfg = 8'(c);
                req      = 4'(p);
                e        = model_pick(8'(c), 4'(p));
                step();
                chk_gnt(c == 0 ? "R7 sweep" : "R5 sweep", oh(e));
                if (e >= 0) last_m = e;
                req = 4'b0;
                step();
                chk_gnt("R4 sweep", 4'b0);
                chk_hurry("R8 idle", 1'b0);
            end
        end

        // R6 directed ties
        prio_cfg = 8'h55; req = 4'b1111; step();
        chk_gnt("R6 tie all", 4'b0001);
        req = 4'b0; step();
        req = 4'b1100; step();
        chk_gnt("R6 tie upper", 4'b0100);
        req = 4'b0; step();
        prio_cfg = 8'b00_10_10_00; req = 4'b0110; step();
        chk_gnt("R6 tie mid", 4'b0010);
        req = 4'b0; step();

        // R3 R10: hold while config and other requests change
        prio_cfg = 8'hC0; req = 4'b0001; step();
        chk_gnt("R3 initial", 4'b0001);
        prio_cfg = 8'h03; req = 4'b1111;
        for (int n = 0; n < 3; n++) begin
            step();
            chk_gnt("R3 hold", 4'b0001);
            chk_gnt("R10 no mid-grant change", 4'b0001);
            chk_hurry("R8 disabled", 1'b0);
        end

        // R8 R9: each hurry source
        hurry_en = 3'b001; step();
        chk_hurry("R8 status src", 1'b1);
        req = 4'b0111; step();
        chk_hurry("R9 status gone", 1'b0);
        hurry_en = 3'b010; step();
        chk_hurry("R8 rxq src", 1'b1);
        hurry_en = 3'b100; step();
        chk_hurry("R8 core src", 1'b1);
        req = 4'b0001; step();
        chk_hurry("R9 core gone", 1'b0);

        // R4 idle gap, then R10 new config used at next decision
        hurry_en = 3'b000; req = 4'b1110; step();
        chk_gnt("R4 gap", 4'b0);
        step();
        chk_gnt("R10 new cfg", 4'b1000);
        hurry_en = 3'b001; step();
        chk_hurry("R8 owner not waiting", 1'b0);
        chk_gnt("R3 still held", 4'b1000);
        hurry_en = 3'b000; req = 4'b0; step();
        chk_gnt("R4 final release", 4'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule